// File: doc/BRIEF.md
# Two-Slot Issue Gate for a Paired Integer/FP Pipeline

This block is the issue stage of a statically scheduled, two-wide, in-order pipeline. Each cycle the fetch side presents one 64-bit packet. The upper half holds an integer-class instruction for the left slot. The lower half holds an FP-class instruction for the right slot. The block decodes both opcodes and all six register fields. It compares them with each other and with the load that issued in the previous cycle. It then issues zero, one or two instructions.

When the packet cannot be fully consumed, `hold` tells the fetcher to present the same packet again on the next cycle. If the left slot issued but the right slot was blocked, the block remembers this internally. On the next cycle only the right instruction is considered. A slot holding an instruction of the wrong class is treated as a no-op and reported on `pair_illegal`.

Top module: `dual_issue_pair_gate`

## Requirements
- R1: The left slot is `pkt[63:32]` and the right slot is `pkt[31:0]`. Each instruction has opcode [31:26], rd [25:21], rs1 [20:16] and rs2 [15:11]. When two legal, independent instructions arrive and no hazard exists, `int_vld` and `fp_vld` are both high in the same cycle and `hold` is low.
- R2: The right instruction issues only in a cycle where the left instruction of the same packet issues, or after it has already issued. When the left slot stalls, neither slot issues and `hold` is high.
- R3: When the left slot is an FP load (opcode 3) and the right FP op reads that load's rd in rs1 or rs2, the left instruction issues, the right one does not, and `hold` is high.
- R4: When an integer load (opcode 2) issued in the previous cycle, and the left instruction reads that load's rd, the left slot stalls. A load reads rs1. An integer ALU op reads rs1 and rs2.
- R5: When an FP load issued in the previous cycle, and the right FP op reads that load's rd, the right slot is blocked that cycle.
- R6: After a cycle in which the left slot issued and the right slot was held, the re-presented packet does not issue its left instruction again. Its right instruction issues once no load hazard remains. For the same-packet FP load case, this happens two cycles after the left slot issued.
- R7: A left opcode with bit 5 set is illegal for that slot. It raises `pair_illegal`, does not raise `int_vld`, and does not prevent the right slot from issuing.
- R8: A right opcode that is nonzero with bit 5 clear is illegal for that slot. It raises `pair_illegal`, does not raise `fp_vld`, and is consumed without blocking.
- R9: Opcode 0 is a no-op in either slot. It raises no valid, creates no hazard and is not illegal.
- R10: While `pkt_vld` is low, and throughout reset, `int_vld`, `fp_vld`, `hold` and `pair_illegal` are all low. Reset leaves no load pending.
- R11: A hazard never crosses register classes. An integer load's rd does not block an FP source. An FP load's rd does not block an integer source.
- R12: Left opcodes 1 and 4 to 31 are integer ALU ops. Right opcodes 32 to 63 are FP ops reading rs1 and rs2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_vld | input | 1 | A fetch packet is present |
| pkt | input | 64 | Packet: left (integer) slot high, right (FP) slot low |
| int_vld | output | 1 | Left instruction issues this cycle |
| fp_vld | output | 1 | Right instruction issues this cycle |
| hold | output | 1 | Packet not consumed; present it again next cycle |
| pair_illegal | output | 1 | A slot holds an instruction of the wrong class |

## Verification
The assertions assume that the fetcher keeps `pkt_vld` high and `pkt` unchanged on every cycle after `hold` was seen. Without that, the replay bookkeeping has no defined packet to act on. The assertions also assume that `pkt_vld` is low during reset. The stimulus meets both assumptions. It models the fetcher as a queue whose head is popped only when `hold` is low. It inserts an idle cycle between directed scenarios, so that each scenario starts with no load pending.

// File: rtl/dual_issue_pair_gate.sv
module dual_issue_pair_gate #(
  parameter int INSN_W = 32,
  parameter int OP_W   = 6,
  parameter int REG_W  = 5,
  parameter int OP_LDI = 2,
  parameter int OP_LDF = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pkt_vld,
  input  logic [2*INSN_W-1:0] pkt,
  output logic                int_vld,
  output logic                fp_vld,
  output logic                hold,
  output logic                pair_illegal
);
  localparam int OP_LO  = INSN_W - OP_W;
  localparam int RD_LO  = OP_LO - REG_W;
  localparam int RS1_LO = RD_LO - REG_W;
  localparam int RS2_LO = RS1_LO - REG_W;

  logic [INSN_W-1:0] li, ri;
  logic [OP_W-1:0]   l_op, r_op;
  logic [REG_W-1:0]  l_rd, l_rs1, l_rs2, r_rs1, r_rs2;

  assign li    = pkt[2*INSN_W-1:INSN_W];
  assign ri    = pkt[INSN_W-1:0];
  assign l_op  = li[INSN_W-1 -: OP_W];
  assign l_rd  = li[RD_LO +: REG_W];
  assign l_rs1 = li[RS1_LO +: REG_W];
  assign l_rs2 = li[RS2_LO +: REG_W];
  assign r_op  = ri[INSN_W-1 -: OP_W];
  assign r_rs1 = ri[RS1_LO +: REG_W];
  assign r_rs2 = ri[RS2_LO +: REG_W];

  logic l_nop, l_bad, l_ldi, l_ldf, l_alu, l_use1;
  logic r_fp, r_bad;
  assign l_nop  = (l_op == '0);
  assign l_bad  = l_op[OP_W-1];
  assign l_ldi  = (l_op == OP_W'(OP_LDI));
  assign l_ldf  = (l_op == OP_W'(OP_LDF));
  assign l_alu  = !l_nop && !l_bad && !l_ldi && !l_ldf;
  assign l_use1 = l_alu || l_ldi || l_ldf;
  assign r_fp   = r_op[OP_W-1];
  assign r_bad  = !r_fp && (r_op != '0);

  logic             left_done;
  logic             ld_vld, ld_fp;
  logic [REG_W-1:0] ld_rd;

  logic l_hz, r_hz_prev, r_hz_same, left_acc, right_acc;
  assign l_hz = ld_vld && !ld_fp &&
                ((l_use1 && l_rs1 == ld_rd) || (l_alu && l_rs2 == ld_rd));
  assign left_acc = pkt_vld && !left_done && !l_hz;
  assign r_hz_prev = ld_vld && ld_fp && r_fp &&
                     (r_rs1 == ld_rd || r_rs2 == ld_rd);
  assign r_hz_same = left_acc && l_ldf && r_fp &&
                     (r_rs1 == l_rd || r_rs2 == l_rd);
  assign right_acc = pkt_vld && (left_done || left_acc) && !r_hz_prev && !r_hz_same;

  assign int_vld      = left_acc && !l_nop && !l_bad;
  assign fp_vld       = right_acc && r_fp;
  assign hold         = pkt_vld && !right_acc;
  assign pair_illegal = pkt_vld && ((!left_done && l_bad) || r_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_done <= 1'b0;
      ld_vld    <= 1'b0;
      ld_fp     <= 1'b0;
      ld_rd     <= '0;
    end else begin
      if (pkt_vld) left_done <= (left_done || left_acc) && !right_acc;
      ld_vld <= left_acc && (l_ldi || l_ldf);
      ld_fp  <= l_ldf;
      ld_rd  <= l_rd;
    end
  end

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_vld |-> !int_vld && !fp_vld && !hold && !pair_illegal);

  // R2
  fp_consumes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_vld |-> !hold);

  // R6
  no_left_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_vld && hold |=> !int_vld);

  // R3
  same_pkt_fld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_vld && fp_vld && l_ldf |-> r_rs1 != l_rd && r_rs2 != l_rd);

  // R5
  fld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fp_vld && $past(rst_n) && $past(int_vld) && $past(l_ldf)
      |-> r_rs1 != $past(l_rd) && r_rs2 != $past(l_rd));

  // R4
  ldi_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_vld && $past(rst_n) && $past(int_vld) && $past(l_ldi)
      |-> l_rs1 != $past(l_rd) && (!l_alu || l_rs2 != $past(l_rd)));
endmodule

// File: tb/dual_issue_pair_gate_tb.sv
module dual_issue_pair_gate_tb;
  logic clk = 1'b0, rst_n = 1'b0, pkt_vld = 1'b0;
  logic [63:0] pkt = '0;
  logic int_vld, fp_vld, hold, pair_illegal;
  int checks = 0, failures = 0, cyc_total = 0;

  always #5 clk = ~clk;

  dual_issue_pair_gate u_dut (.clk(clk), .rst_n(rst_n), .pkt_vld(pkt_vld), .pkt(pkt),
    .int_vld(int_vld), .fp_vld(fp_vld), .hold(hold), .pair_illegal(pair_illegal));

  // reference state
  bit m_done = 0;
  int m_kind = 0, m_rd = 0;
  logic [63:0] q[$];

  function automatic logic [31:0] mk(int op, int rd, int a, int b);
    mk = {op[5:0], rd[4:0], a[4:0], b[4:0], 11'd0};
  endfunction

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, bit vld, logic [63:0] p, output bit held);
    int lop, lrd, l1, l2, rop, r1, r2;
    bit lalu, lrd1, lblk, lgo, rfp, rblk, rgo, e_int, e_fp, e_hold, e_ill;
    @(negedge clk);
    pkt_vld = vld; pkt = p;
    #2;
    lop = int'(p[63:58]); lrd = int'(p[57:53]); l1 = int'(p[52:48]); l2 = int'(p[47:43]);
    rop = int'(p[31:26]); r1 = int'(p[20:16]); r2 = int'(p[15:11]);
    lalu = (lop != 0) && (lop < 32) && (lop != 2) && (lop != 3);
    lrd1 = lalu || lop == 2 || lop == 3;
    rfp  = rop >= 32;
    lblk = (m_kind == 1) && ((lrd1 && l1 == m_rd) || (lalu && l2 == m_rd));
    lgo  = vld && !m_done && !lblk;
    rblk = (m_kind == 2 && rfp && (r1 == m_rd || r2 == m_rd)) ||
           (lgo && lop == 3 && rfp && (r1 == lrd || r2 == lrd));
    rgo  = vld && (m_done || lgo) && !rblk;
    e_int  = lgo && lop != 0 && lop < 32;
    e_fp   = rgo && rfp;
    e_hold = vld && !rgo;
    e_ill  = vld && ((!m_done && lop >= 32) || (!rfp && rop != 0));
    chk(tag, "int_vld", int_vld, e_int);
    chk(tag, "fp_vld", fp_vld, e_fp);
    chk(tag, "hold", hold, e_hold);
    chk(tag, "pair_illegal", pair_illegal, e_ill);
    m_kind = (lgo && lop == 2) ? 1 : (lgo && lop == 3) ? 2 : 0;
    m_rd = lrd;
    if (vld) m_done = (m_done || lgo) && !rgo;
    held = e_hold;
    cyc_total++;
  endtask

  task automatic drain(string tag, int exp_cycles);
    int n = 0;
    bit h;
    while (q.size() > 0) begin
      step(tag, 1'b1, q[0], h);
      if (!h) void'(q.pop_front());
      n++;
    end
    step(tag, 1'b0, '0, h);
    if (exp_cycles >= 0) begin
      checks++;
      if (n != exp_cycles) begin
        failures++;
        $display("FAIL %s cycle_count actual=%0d expected=%0d", tag, n, exp_cycles);
      end
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    bit h;
    repeat (3) @(posedge clk);
    #2;
    chk("R10", "reset int_vld", int_vld, 1'b0);
    chk("R10", "reset fp_vld", fp_vld, 1'b0);
    chk("R10", "reset hold", hold, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    step("R10", 1'b0, '0, h);

    q.push_back({mk(1, 1, 2, 3), mk(32, 1, 2, 3)});            drain("R1", 1);
    q.push_back({mk(12, 7, 0, 0), mk(45, 4, 9, 9)});           drain("R12", 1);
    q.push_back({mk(3, 4, 1, 0), mk(33, 5, 4, 6)});            drain("R3", 3);
    q.push_back({mk(3, 4, 1, 0), mk(33, 5, 6, 4)});
    q.push_back({mk(1, 1, 2, 3), mk(32, 2, 3, 3)});            drain("R6", 4);
    q.push_back({mk(2, 5, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(1, 6, 5, 2), mk(32, 1, 2, 3)});            drain("R4", 3);
    q.push_back({mk(2, 5, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(1, 6, 2, 5), mk(32, 1, 2, 3)});            drain("R2", 3);
    q.push_back({mk(3, 7, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(1, 1, 2, 3), mk(34, 8, 1, 7)});            drain("R5", 3);
    q.push_back({mk(2, 9, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(1, 1, 2, 3), mk(32, 1, 9, 9)});            drain("R11", 2);
    q.push_back({mk(3, 10, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(1, 1, 10, 10), mk(0, 0, 0, 0)});           drain("R11", 2);
    q.push_back({mk(37, 1, 2, 3), mk(32, 1, 2, 3)});           drain("R7", 1);
    q.push_back({mk(1, 1, 2, 3), mk(5, 1, 2, 3)});             drain("R8", 1);
    q.push_back({mk(0, 0, 0, 0), mk(0, 0, 0, 0)});             drain("R9", 1);
    q.push_back({mk(3, 3, 1, 0), mk(0, 0, 0, 0)});
    q.push_back({mk(0, 3, 3, 3), mk(0, 0, 0, 0)});             drain("R9", 2);

    for (int i = 0; i < 400; i++) begin
      int lsel = $urandom_range(0, 9);
      int rsel = $urandom_range(0, 9);
      int lop  = (lsel < 3) ? 2 + (lsel % 2) : (lsel == 9) ? 40 : (lsel == 8) ? 0 : 1;
      int rop  = (rsel == 9) ? 6 : (rsel == 8) ? 0 : 32 + rsel;
      q.push_back({mk(lop, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3)),
                   mk(rop, $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3))});
    end
    drain("R2", -1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule